// File: doc/BRIEF.md
# Successive-Approximation Converter Host Sequencer

This block drives a 16-bit successive-approximation converter over a three-wire handshake: a sample request, a busy flag returned by the converter, and a conversion clock. All of it runs from one fast system clock. A binary rate counter produces a square-wave sample request. While the request is high the converter acquires its input, and when the request falls the converter raises busy and starts converting. The host holds the conversion clock low whenever busy is low. Once busy is high it releases the divider, which emits exactly the number of rising edges one conversion needs (17 by default) and then parks high. When busy drops, that last high phase is cut short.

The falling edge of busy, after synchronisation, captures the converter's parallel word. The word is presented for one system-clock cycle with a valid strobe, either as the raw two's-complement code or with its top bit inverted to give offset binary. A conversion-time watchdog raises a sticky error when busy has not fallen within a set number of system-clock cycles after the sample request rose. Because the request is a free-running square wave, the converter runs back to back at the selected rate.

Top module: `sar_host_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sampleReq`, `convClk`, `dataValid` and `timeoutErr` are all low.
- R2: `sampleReq` is a square wave that is high for half of its period. The period is 128 system-clock cycles when `rateSel` is 0 and 256 cycles when `rateSel` is 1.
- R3: `sampleReq` changes state only on a clock edge at which `convClk` is low.
- R4: `convClk` is low from the fourth clock edge after `busyIn` falls until `busyIn` rises again. It therefore shows no rising edge during acquisition.
- R5: After `busyIn` rises, `convClk` starts in its low phase. Its low phase lasts CLK_LO_CYC cycles and its high phase lasts CLK_HI_CYC cycles, with CLK_LO_CYC no smaller than CLK_HI_CYC (1 and 1 by default). It gives exactly PULSES (17) rising edges and then stays high until the busy fall truncates that pulse.
- R6: `dataValid` is a one-cycle pulse asserted on the third rising clock edge after `busyIn` falls.
- R7: With `offsetBin` 0, `dataOut` equals `convData` captured at that edge. With `offsetBin` 1, bit 15 is inverted and all other bits are unchanged.
- R8: `timeoutErr` goes high on the (TIMEOUT_CYC+1)th rising edge after the edge on which `sampleReq` rose, if busy has not fallen in between. It then stays high until reset. A normal conversion never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rateSel | input | 1 | Sample rate select: 0 divides by 128, 1 divides by 256 |
| offsetBin | input | 1 | 1 presents the result as offset binary |
| busyIn | input | 1 | Busy flag from the converter (asynchronous) |
| convData | input | 16 | Parallel result word from the converter |
| sampleReq | output | 1 | Sample request to the converter |
| convClk | output | 1 | Conversion clock to the converter |
| dataOut | output | 16 | Captured and formatted result |
| dataValid | output | 1 | One-cycle strobe for dataOut |
| timeoutErr | output | 1 | Sticky conversion-time error |

## Verification
The bench feeds the extreme codes +full scale, -full scale, zero and -1 in both output formats. A wrong top-bit flip or a capture taken before the word settles therefore shows up as a data mismatch. It counts every conversion-clock rising edge seen while busy is low. A divider that is not gated after the last pulse, or that runs during acquisition, would leave an extra edge there. It measures the sample period and high time at both rates, and the exact latency from busy falling to the valid strobe. With the converter silenced, it checks the precise cycle on which the watchdog fires, so an off-by-one limit or a timer that restarts on every request would be caught.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic divRun;   // conversion clock divider may run (synchronised busy)
    logic capture;  // latch the converter word this cycle
  } seqStrobe_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int RATE_LO_LOG2 = 7,
  parameter int RATE_HI_LOG2 = 8,
  parameter int TIMEOUT_CYC  = 12288
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busyIn,
  input  logic       rateSel,
  input  logic       convClkIn,
  output logic       sampleReq,
  output logic       timeoutErr,
  output seqStrobe_t strobe
);

  localparam int RATE_W = (RATE_HI_LOG2 > RATE_LO_LOG2) ? RATE_HI_LOG2 : RATE_LO_LOG2;
  localparam int TMR_W  = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);
  localparam logic [TMR_W-1:0] TMR_MAX  = TMR_W'(TIMEOUT_CYC);

  generate
    if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  // Busy synchroniser and edge detect
  logic [SYNC_STAGES-1:0] busySync;
  logic busyPrev;
  logic busyNow;
  logic busyFall;

  assign busyNow  = busySync[SYNC_STAGES-1];
  assign busyFall = busyPrev & ~busyNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      busySync <= '0;
      busyPrev <= 1'b0;
    end else begin
      busySync <= {busySync[SYNC_STAGES-2:0], busyIn};
      busyPrev <= busyNow;
    end
  end

  // Rate counter and sample request
  logic [RATE_W-1:0] rateCnt;
  logic rateTap;
  logic sampleDly;
  logic sampleRise;

  assign rateTap    = rateSel ? rateCnt[RATE_HI_LOG2-1] : rateCnt[RATE_LO_LOG2-1];
  assign sampleRise = sampleReq & ~sampleDly;

  always_ff @(posedge clk) begin
    if (rst) begin
      rateCnt   <= '0;
      sampleReq <= 1'b0;
      sampleDly <= 1'b0;
    end else begin
      rateCnt   <= rateCnt + 1'b1;
      sampleDly <= sampleReq;
      // edges of the request only while the conversion clock is low
      if (!convClkIn) sampleReq <= rateTap;
    end
  end

  // Conversion-time watchdog
  logic armed;
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      tmr        <= '0;
      timeoutErr <= 1'b0;
    end else begin
      if (busyFall) begin
        armed <= 1'b0;
        tmr   <= '0;
      end else if (sampleRise && !armed) begin
        armed <= 1'b1;
        tmr   <= '0;
      end else if (armed && tmr != TMR_MAX) begin
        tmr <= tmr + 1'b1;
      end
      if (armed && !busyFall && tmr == TMR_LAST) timeoutErr <= 1'b1;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.divRun  = busyNow;
    strobe.capture = busyFall;
  end

endmodule

// File: rtl/sar_seq_dpath.sv
module sar_seq_dpath
  import sar_seq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PULSES     = 17,
  parameter int CLK_LO_CYC = 1,
  parameter int CLK_HI_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] convData,
  input  logic              offsetBin,
  output logic              convClk,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);

  localparam int PH_MAX = (CLK_LO_CYC > CLK_HI_CYC) ? CLK_LO_CYC : CLK_HI_CYC;
  localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
  localparam int PC_W   = $clog2(PULSES + 1);
  localparam logic [PH_W-1:0] LO_END = PH_W'(CLK_LO_CYC - 1);
  localparam logic [PH_W-1:0] HI_END = PH_W'(CLK_HI_CYC - 1);

  generate
    if (CLK_LO_CYC < CLK_HI_CYC) begin : g_bad_duty
      $error("conversion clock low phase must be at least half the period");
    end
  endgenerate

  // Gated conversion clock divider
  logic [PH_W-1:0] phaseCnt;
  logic [PC_W-1:0] pulseCnt;
  logic burstDone;
  logic phaseEnd;

  assign burstDone = (pulseCnt == PC_W'(PULSES));
  assign phaseEnd  = (phaseCnt == (convClk ? HI_END : LO_END));

  always_ff @(posedge clk) begin
    if (rst || !strobe.divRun) begin
      phaseCnt <= '0;
      pulseCnt <= '0;
      convClk  <= 1'b0;
    end else if (!burstDone) begin
      if (phaseEnd) begin
        phaseCnt <= '0;
        convClk  <= ~convClk;
        if (!convClk) pulseCnt <= pulseCnt + 1'b1;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  // Result capture and output coding
  logic [DATA_W-1:0] coded;
  assign coded = {convData[DATA_W-1] ^ offsetBin, convData[DATA_W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strobe.capture;
      if (strobe.capture) dataOut <= coded;
    end
  end

endmodule

// File: rtl/sar_host_seq.sv
module sar_host_seq
  import sar_seq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int PULSES       = 17,
  parameter int CLK_LO_CYC   = 1,
  parameter int CLK_HI_CYC   = 1,
  parameter int SYNC_STAGES  = 2,
  parameter int RATE_LO_LOG2 = 7,
  parameter int RATE_HI_LOG2 = 8,
  parameter int TIMEOUT_CYC  = 12288
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rateSel,
  input  logic              offsetBin,
  input  logic              busyIn,
  input  logic [DATA_W-1:0] convData,
  output logic              sampleReq,
  output logic              convClk,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              timeoutErr
);

  seqStrobe_t strobe;

  sar_seq_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .RATE_LO_LOG2(RATE_LO_LOG2),
    .RATE_HI_LOG2(RATE_HI_LOG2),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .busyIn    (busyIn),
    .rateSel   (rateSel),
    .convClkIn (convClk),
    .sampleReq (sampleReq),
    .timeoutErr(timeoutErr),
    .strobe    (strobe)
  );

  sar_seq_dpath #(
    .DATA_W    (DATA_W),
    .PULSES    (PULSES),
    .CLK_LO_CYC(CLK_LO_CYC),
    .CLK_HI_CYC(CLK_HI_CYC)
  ) i_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .convData (convData),
    .offsetBin(offsetBin),
    .convClk  (convClk),
    .dataOut  (dataOut),
    .dataValid(dataValid)
  );

endmodule

// File: rtl/sar_host_seq_chk.sv
module sar_host_seq_chk #(
  parameter int PULSES = 17
) (
  input logic clk,
  input logic rst,
  input logic busyIn,
  input logic sampleReq,
  input logic convClk,
  input logic dataValid,
  input logic timeoutErr
);

  localparam int RC_W = $clog2(PULSES + 2);

  logic rstDly;
  logic clkDly;
  logic [RC_W-1:0] riseCnt;

  always_ff @(posedge clk) begin
    rstDly <= rst;
    if (rst) begin
      clkDly  <= 1'b0;
      riseCnt <= '0;
    end else begin
      clkDly <= convClk;
      if (!busyIn) riseCnt <= '0;
      else if (convClk && !clkDly && riseCnt != RC_W'(PULSES + 1)) riseCnt <= riseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rstDly) begin
      // R1
      reset_state_chk: assert (!sampleReq && !convClk && !dataValid && !timeoutErr);
    end
  end

  // R3
  sample_phase_chk: assert property (@(posedge clk) disable iff (rst)
    convClk |=> $stable(sampleReq));

  // R4
  clk_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!busyIn && !$past(busyIn) && !$past(busyIn, 2) && !$past(busyIn, 3)) |-> !convClk);

  // R5
  pulse_count_chk: assert property (@(posedge clk) disable iff (rst)
    riseCnt <= RC_W'(PULSES));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !dataValid);

  // R8
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    timeoutErr |=> timeoutErr);

endmodule

bind sar_host_seq sar_host_seq_chk #(.PULSES(PULSES)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .busyIn    (busyIn),
  .sampleReq (sampleReq),
  .convClk   (convClk),
  .dataValid (dataValid),
  .timeoutErr(timeoutErr)
);

// File: tb/test_sar_host_seq.sv
module test_sar_host_seq;

  localparam int TO_CYC = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rateSel = 1'b0;
  logic offsetBin = 1'b0;
  logic busyIn = 1'b0;
  logic [15:0] convData = '0;
  logic sampleReq, convClk, dataValid, timeoutErr;
  logic [15:0] dataOut;

  sar_host_seq #(.TIMEOUT_CYC(TO_CYC)) i_sar_host_seq (
    .clk(clk), .rst(rst), .rateSel(rateSel), .offsetBin(offsetBin),
    .busyIn(busyIn), .convData(convData), .sampleReq(sampleReq),
    .convClk(convClk), .dataOut(dataOut), .dataValid(dataValid),
    .timeoutErr(timeoutErr)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] wordFor(input int i);
    case (i % 6)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'h0000;
      3: return 16'hFFFF;
      4: return 16'h0001;
      default: return 16'(i * 4951 + 777);
    endcase
  endfunction

  // Scoreboard
  logic [15:0] expWord[$];
  int expCyc[$];
  bit modelEn = 1'b1;
  int convIdx = 0;

  // Behavioural converter: acquire while the request is high, convert after it falls
  initial begin
    forever begin
      @(negedge sampleReq);
      if (modelEn && !rst) begin
        logic [15:0] w;
        busyIn = 1'b1;
        repeat (17) @(posedge convClk);
        w = wordFor(convIdx);
        convIdx++;
        convData = w;
        busyIn = 1'b0;
        @(negedge clk);
        expWord.push_back(offsetBin ? (w ^ 16'h8000) : w);
        expCyc.push_back(cyc + 3);
      end
    end
  end

  // Monitor
  int expPeriod = 128;
  int lastRise = -1;
  logic samplePrev = 1'b0;
  logic clkPrev = 1'b0;
  logic busyPrevM = 1'b0;
  int lastClkEdge = 0;
  int convRises = 0;
  int extraRises = 0;
  int badWidth = 0;
  int periodChecks = 0;

  always @(negedge clk) begin
    if (rst) begin
      lastRise   = -1;
      samplePrev = 1'b0;
      clkPrev    = 1'b0;
      busyPrevM  = 1'b0;
      convRises  = 0;
    end else begin
      if (dataValid) begin
        if (expWord.size() == 0) begin
          check(1'b0, "R6", "unexpected valid", dataOut, 0);
        end else begin
          logic [15:0] w;
          int c;
          w = expWord.pop_front();
          c = expCyc.pop_front();
          check(dataOut == w, "R7", "result word", dataOut, w);
          check(cyc == c, "R6", "valid latency cycle", cyc, c);
          check(convClk == 1'b0, "R5", "conv clock after truncated pulse", convClk, 0);
        end
      end
      if (sampleReq != samplePrev) begin
        check(clkPrev == 1'b0, "R3", "conv clock at request edge", clkPrev, 0);
        if (sampleReq) begin
          if (lastRise >= 0) begin
            check(cyc - lastRise == expPeriod, "R2", "request period", cyc - lastRise, expPeriod);
            periodChecks++;
          end
          lastRise = cyc;
        end else if (lastRise >= 0) begin
          check(cyc - lastRise == expPeriod / 2, "R2", "request high time", cyc - lastRise, expPeriod / 2);
        end
      end
      if (!busyIn && !busyPrevM) convRises = 0;
      if (convClk != clkPrev) begin
        if (convClk) begin
          if (!busyIn && !busyPrevM) extraRises++;
          if (convRises > 0 && cyc - lastClkEdge != 1) badWidth++;
          convRises++;
        end else if (busyIn && cyc - lastClkEdge != 1) begin
          badWidth++;
        end
        lastClkEdge = cyc;
      end
      samplePrev = sampleReq;
      clkPrev    = convClk;
      busyPrevM  = busyIn;
    end
  end

  task automatic runAll();
    int t;
    // R1: reset state
    repeat (4) @(negedge clk);
    check(!sampleReq && !convClk && !dataValid && !timeoutErr, "R1", "outputs in reset",
          {sampleReq, convClk, dataValid, timeoutErr}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!sampleReq && !convClk && !dataValid && !timeoutErr, "R1", "outputs after reset",
          {sampleReq, convClk, dataValid, timeoutErr}, 0);

    // Two's complement at the fast rate
    while (convIdx < 10) @(negedge clk);
    while (expWord.size() != 0) @(negedge clk);
    check(timeoutErr == 1'b0, "R8", "no timeout on normal conversions", timeoutErr, 0);

    // Offset binary at the slow rate
    @(posedge sampleReq);
    @(negedge clk);
    rst = 1'b1; rateSel = 1'b1; offsetBin = 1'b1; expPeriod = 256;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    while (convIdx < 18) @(negedge clk);
    while (expWord.size() != 0) @(negedge clk);
    check(timeoutErr == 1'b0, "R8", "no timeout at slow rate", timeoutErr, 0);

    // Silent converter: watchdog
    @(posedge sampleReq);
    @(negedge clk);
    modelEn = 1'b0; rst = 1'b1; rateSel = 1'b0; expPeriod = 128;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge sampleReq);
    @(negedge clk);
    t = cyc;
    while (cyc < t + TO_CYC) @(negedge clk);
    check(timeoutErr == 1'b0, "R8", "error one cycle before limit", timeoutErr, 0);
    @(negedge clk);
    check(timeoutErr == 1'b1, "R8", "error at limit", timeoutErr, 1);
    repeat (200) @(negedge clk);
    check(timeoutErr == 1'b1, "R8", "error sticky", timeoutErr, 1);
    rst = 1'b1;
    @(negedge clk);
    check(timeoutErr == 1'b0, "R1", "reset clears error", timeoutErr, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    check(extraRises == 0, "R4", "conv clock rises while busy low", extraRises, 0);
    check(badWidth == 0, "R5", "conv clock phase width errors", badWidth, 0);
    check(periodChecks >= 8, "R2", "request periods observed", periodChecks, 8);
  endtask

  initial begin
    bit timedOut = 1'b0;
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) check(1'b0, "R1", "watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule